// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a register-driven master for the two-wire PHY management bus. Software writes one 32-bit command word into the command register. The word carries a start flag, a read or write selector, the PHY address, the PHY register number and, for a write, the 16-bit value to send. The block then runs one clause 22 management frame on MDC and MDIO, releases MDIO for the turnaround and data of a read, and shifts the returned value into a data register.

The start flag in the command register reads back as 1 for as long as the frame runs. Software polls it and issues the next command only after it has cleared. MDC comes from the block clock, taken to be the 25 MHz reference, through a divider. An 8-bit field N in the control register sets the divider, so MDC runs at f_clk / (2 × (N + 1)). The reset value N = 4 gives 2.5 MHz. MDIO is brought out as separate output, output-enable and input pins so that the pad ring can build the tristate buffer.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset the command register (word 0) reads 0, the data register (word 1) reads 0, the control register (word 2) reads 0x0400_0000, MDC is low, MDIO is not driven (`mdio_oe` = 0) and `mdio_o` is 1.
- R2: A write to word 0 starts a frame when bit 15 is set, exactly one of bit 11 (read) and bit 10 (write) is set, and no frame is running. From the next cycle word 0 reads back the written word with bit 15 = 1 until the frame ends.
- R3: MDC is low while idle. During a frame MDC rises N+1 cycles after the accepting edge and then toggles every N+1 cycles, where N = word 2 bits [31:24].
- R4: The frame is 64 bits, sent MSB first, each bit held for one MDC period and changed on MDC falling edges. It consists of 32 ones, start 01, opcode 10 (read) or 01 (write), PHY address from command bits [9:5], register number from bits [4:0], and turnaround. A write then sends turnaround 10 followed by command bits [31:16].
- R5: In a read, `mdio_oe` is 0 from the first turnaround bit (frame bit 46) to the end of the frame. The 16 data bits are sampled from `mdio_i` on MDC rising edges, MSB first.
- R6: The busy flag (word 0 bit 15) clears, and after a read the data register updates, on the clock edge that ends the last frame bit. This edge comes exactly 128 × (N+1) cycles after the accepting edge.
- R7: A write to word 0 while a frame runs has no effect on the frame or on the command register.
- R8: A write to word 0 with bit 15 clear, or with both or neither of bits 11 and 10 set, starts no frame and leaves word 0 unchanged.
- R9: A write frame leaves the data register unchanged.
- R10: Word 1 reads the last read value in bits [15:0] and 0 above. Word 2 reads N in bits [31:24] and 0 elsewhere. Word 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, also the MDC reference |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index (0 command, 1 data, 2 control) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in from the pad |

## Verification
The reference model counts the cycles since the accepting edge, j. It expects MDC to be (j / (N+1)) mod 2 and frame bit j / (2(N+1)) on MDIO. The busy flag clears at j = 128(N+1), which is also the cycle the new read value appears. The model is compared on every falling clock edge, half a cycle after the registers settle. Register reads are compared in that same half cycle, because the read path is combinational. The PHY side of the bench drives each returned bit at the falling edge before the MDC rising edge that samples it. A directed count of busy cycles pins the completion edge for three divider settings.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DATA_W     = 16;
    localparam int FIELD_W    = 5;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = 64;
    // Frame bit index of the first turnaround bit and of the first data bit.
    localparam int TA_FIRST   = PRE_BITS + 2 + 2 + 2 * FIELD_W;
    localparam int RX_FIRST   = TA_FIRST + 2;

    // Command word layout: the positions are fixed by the software contract.
    typedef struct packed {
        logic [DATA_W-1:0]  wr_data;   // [31:16]
        logic               req;       // [15]
        logic [2:0]         rsvd;      // [14:12]
        logic               op_rd;     // [11]
        logic               op_wr;     // [10]
        logic [FIELD_W-1:0] phy_ad;    // [9:5]
        logic [FIELD_W-1:0] reg_ad;    // [4:0]
    } cmd_word_t;

endpackage

// File: rtl/mdio_mdc_div.sv
module mdio_mdc_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DIV_W-1:0] div_n,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             mdc;
    } div_st_t;

    div_st_t q, d;
    logic    tick;

    always_comb begin
        d    = q;
        tick = en && (q.cnt == div_n);
        if (!en) begin
            d.cnt = '0;
            d.mdc = 1'b0;
        end else if (tick) begin
            d.cnt = '0;
            d.mdc = ~q.mdc;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mdc       = q.mdc;
    assign rise_tick = tick && !q.mdc;
    assign fall_tick = tick &&  q.mdc;

    // R3
    mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !mdc);

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  cmd_word_t         cmd,
    input  logic              rise_tick,
    input  logic              fall_tick,
    input  logic              mdio_i,
    output logic              busy,
    output logic [DATA_W-1:0] rd_value,
    output logic              mdio_o,
    output logic              mdio_oe
);

    localparam int IDX_W = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_FIRST);
    localparam logic [IDX_W-1:0] RX_IDX   = IDX_W'(RX_FIRST);

    typedef struct packed {
        logic                  busy;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] frame;
        logic [DATA_W-1:0]     rx;
        logic [DATA_W-1:0]     rdval;
    } seq_st_t;

    seq_st_t q, d;
    logic    last_fall;

    logic unused_cmd;
    assign unused_cmd = ^{cmd.req, cmd.rsvd, cmd.op_wr};

    always_comb begin
        d         = q;
        last_fall = q.busy && fall_tick && (q.idx == LAST_IDX);
        if (start) begin
            d.busy  = 1'b1;
            d.rd    = cmd.op_rd;
            d.idx   = '0;
            d.rx    = '0;
            d.frame = {{PRE_BITS{1'b1}}, 2'b01,
                       cmd.op_rd ? 2'b10 : 2'b01,
                       cmd.phy_ad, cmd.reg_ad,
                       cmd.op_rd ? 2'b11 : 2'b10,
                       cmd.op_rd ? {DATA_W{1'b1}} : cmd.wr_data};
        end else if (q.busy) begin
            if (rise_tick && q.rd && (q.idx >= RX_IDX))
                d.rx = {q.rx[DATA_W-2:0], mdio_i};
            if (fall_tick) begin
                d.frame = {q.frame[FRAME_BITS-2:0], 1'b1};
                d.idx   = q.idx + 1'b1;
                if (q.idx == LAST_IDX) begin
                    d.busy = 1'b0;
                    if (q.rd) d.rdval = q.rx;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy     = q.busy;
    assign rd_value = q.rdval;
    assign mdio_oe  = q.busy && !(q.rd && (q.idx >= TA_IDX));
    assign mdio_o   = q.busy ? q.frame[FRAME_BITS-1] : 1'b1;

    // R6
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_fall |=> !busy);

    // R6
    rdval_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !last_fall |=> $stable(rd_value));

    // R4
    preamble_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (mdio_oe && mdio_o));

    // R5
    release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && q.rd && !mdio_oe) |=> !mdio_oe);

endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 4,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              busy,
    input  logic [DATA_W-1:0] rd_value,
    output logic              start,
    output cmd_word_t         cmd,
    output logic [DIV_W-1:0]  div_n,
    output logic [31:0]       reg_rdata
);

    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);
    localparam int DIV_LSB = 32 - DIV_W;

    typedef struct packed {
        cmd_word_t        cmd;
        logic [DIV_W-1:0] div;
    } reg_st_t;

    reg_st_t   q, d;
    cmd_word_t wr_cmd;
    cmd_word_t shown;
    logic      cmd_wr;

    assign wr_cmd = cmd_word_t'(reg_wdata);

    always_comb begin
        d      = q;
        cmd_wr = reg_we && (reg_addr == A_CMD);
        start  = cmd_wr && wr_cmd.req && (wr_cmd.op_rd ^ wr_cmd.op_wr) && !busy;
        if (start) d.cmd = wr_cmd;
        if (reg_we && (reg_addr == A_CTRL)) d.div = reg_wdata[31:DIV_LSB];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cmd <= '0;
            q.div <= DIV_W'(DEF_DIV);
        end else begin
            q <= d;
        end
    end

    always_comb begin
        shown     = q.cmd;
        shown.req = busy;
        unique case (reg_addr)
            A_CMD:   reg_rdata = shown;
            A_DATA:  reg_rdata = {{(32 - DATA_W){1'b0}}, rd_value};
            A_CTRL:  reg_rdata = {q.div, {DIV_LSB{1'b0}}};
            default: reg_rdata = '0;
        endcase
    end

    assign cmd   = wr_cmd;
    assign div_n = q.div;

    // R7
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_we && (reg_addr == A_CMD)) |=> $stable(q.cmd));

    // R8
    bad_op_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == A_CMD) && !(reg_wdata[11] ^ reg_wdata[10]))
            |=> $stable(q.cmd));

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 4,
    parameter int ADDR_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);

    logic              start;
    cmd_word_t         cmd;
    logic [DIV_W-1:0]  div_n;
    logic              busy;
    logic [DATA_W-1:0] rd_value;
    logic              rise_tick;
    logic              fall_tick;

    mdio_regs #(
        .DIV_W  (DIV_W),
        .DEF_DIV(DEF_DIV),
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .busy     (busy),
        .rd_value (rd_value),
        .start    (start),
        .cmd      (cmd),
        .div_n    (div_n),
        .reg_rdata(reg_rdata)
    );

    mdio_mdc_div #(
        .DIV_W(DIV_W)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (busy),
        .div_n    (div_n),
        .mdc      (mdc),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick)
    );

    mdio_frame_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cmd      (cmd),
        .rise_tick(rise_tick),
        .fall_tick(fall_tick),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .rd_value (rd_value),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe)
    );

    // R3
    mdc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

endmodule

// File: tb/mdio_cmd_ctrl_test.sv
`timescale 1ns/100ps
module mdio_cmd_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    always #2 clk = ~clk;

    mdio_cmd_ctrl #(.DIV_W(8), .DEF_DIV(4), .ADDR_W(2)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Behavioural reference model state
    bit          m_busy = 0;
    bit          m_rd = 0;
    int          m_j = 0;
    int          m_h = 1;
    logic [63:0] m_frame = '0;
    logic [31:0] m_cmd = '0;
    logic [15:0] m_data = '0;
    logic [7:0]  m_div = 8'd4;
    logic [15:0] phy_word = 16'h0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0:    return {m_cmd[31:16], m_busy, m_cmd[14:0]};
            2'd1:    return {16'h0, m_data};
            2'd2:    return {m_div, 24'h0};
            default: return 32'h0;
        endcase
    endfunction

    always @(negedge clk) begin
        int k;
        bit e_oe;
        logic e_mdc;
        if (!rst_n) begin
            m_busy = 0; m_cmd = '0; m_data = '0; m_div = 8'd4; m_j = 0; m_h = 1;
            mdio_i = 1'b1;
        end else begin
            k     = m_busy ? m_j / (2 * m_h) : 0;
            e_mdc = m_busy ? logic'((m_j / m_h) % 2) : 1'b0;
            e_oe  = m_busy && !(m_rd && k >= 46);
            check("R3", "mdc", {31'h0, mdc}, {31'h0, e_mdc});
            check(m_rd ? "R5" : "R4", "mdio_oe", {31'h0, mdio_oe}, {31'h0, e_oe});
            if (e_oe) check("R4", "mdio_o", {31'h0, mdio_o}, {31'h0, m_frame[63 - k]});
            if (!m_busy) check("R1", "idle mdio_o", {31'h0, mdio_o}, 32'h1);
            check(reg_addr == 2'd0 ? "R2" : (reg_addr == 2'd1 ? "R6" : "R10"),
                  "reg_rdata", reg_rdata, m_rdata(reg_addr));
            // PHY side: present the bit for the current frame position
            if (m_busy && m_rd && k >= 48) mdio_i = phy_word[63 - k];
            else                           mdio_i = 1'b1;
            // Advance the model to the state after the coming rising edge
            if (m_busy) begin
                m_j++;
                if (m_j == 128 * m_h) begin
                    m_busy = 0;
                    if (m_rd) m_data = phy_word;
                end
            end else if (reg_we && reg_addr == 2'd0 && reg_wdata[15] &&
                         (reg_wdata[11] ^ reg_wdata[10])) begin
                m_busy  = 1;
                m_rd    = reg_wdata[11];
                m_j     = 0;
                m_h     = int'(m_div) + 1;
                m_cmd   = reg_wdata;
                m_frame = {32'hFFFF_FFFF, 2'b01, reg_wdata[11] ? 2'b10 : 2'b01,
                           reg_wdata[9:5], reg_wdata[4:0], 2'b10, reg_wdata[31:16]};
            end
            if (reg_we && reg_addr == 2'd2) m_div = reg_wdata[31:24];
        end
    end

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0; reg_addr = 2'd0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        #0.5;
        check(tag, "register read", reg_rdata, exp);
        reg_addr = 2'd0;
    endtask

    task automatic run_cmd(input logic [31:0] c, input int h, input string tag);
        int cnt;
        cnt = 0;
        wr_reg(2'd0, c);
        forever begin
            @(negedge clk);
            if (reg_rdata[15]) cnt++;
            else break;
        end
        check(tag, "busy cycles", cnt, 128 * h);
    endtask

    task automatic wait_idle();
        while (m_busy) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    localparam logic [31:0] WR_CMD  = {16'hA5C3, 1'b1, 3'b0, 1'b0, 1'b1, 5'h11, 5'h0A};
    localparam logic [31:0] RD_CMD  = {16'h0000, 1'b1, 3'b0, 1'b1, 1'b0, 5'h03, 5'h1F};
    localparam logic [31:0] RD_CMD2 = {16'h0000, 1'b1, 3'b0, 1'b1, 1'b0, 5'h1F, 5'h00};

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd_chk(2'd0, 32'h0, "R1");
        rd_chk(2'd1, 32'h0, "R1");
        rd_chk(2'd2, 32'h0400_0000, "R1");

        // R10 control field and unmapped word
        wr_reg(2'd2, 32'h01FF_FFFF);
        rd_chk(2'd2, 32'h0100_0000, "R10");
        rd_chk(2'd3, 32'h0, "R10");

        // R4 write frame with N=1, then R9 data register untouched
        run_cmd(WR_CMD, 2, "R6");
        rd_chk(2'd1, 32'h0, "R9");
        rd_chk(2'd0, {WR_CMD[31:16], 1'b0, WR_CMD[14:0]}, "R2");

        // R5 read frame, with an R7 command issued mid-frame
        phy_word = 16'hBEEF;
        wr_reg(2'd0, RD_CMD);
        repeat (20) @(posedge clk);
        wr_reg(2'd0, WR_CMD);
        rd_chk(2'd0, {RD_CMD[31:16], 1'b1, RD_CMD[14:0]}, "R7");
        wait_idle();
        rd_chk(2'd1, 32'h0000_BEEF, "R5");
        rd_chk(2'd0, {RD_CMD[31:16], 1'b0, RD_CMD[14:0]}, "R7");

        // R8 malformed commands are ignored
        wr_reg(2'd0, WR_CMD & ~32'h0000_8000);
        wr_reg(2'd0, WR_CMD | 32'h0000_0800);
        wr_reg(2'd0, WR_CMD & ~32'h0000_0400);
        repeat (3) @(posedge clk);
        #1 check("R8", "mdio_oe", {31'h0, mdio_oe}, 32'h0);
        rd_chk(2'd0, {RD_CMD[31:16], 1'b0, RD_CMD[14:0]}, "R8");

        // R6 completion timing with N=0 and with N=4
        wr_reg(2'd2, 32'h0000_0000);
        phy_word = 16'h0001;
        run_cmd(RD_CMD2, 1, "R6");
        rd_chk(2'd1, 32'h0000_0001, "R6");

        wr_reg(2'd2, 32'h0400_0000);
        phy_word = 16'h8000;
        run_cmd(RD_CMD2, 5, "R6");
        rd_chk(2'd1, 32'h0000_8000, "R6");

        // R9 a write after a read keeps the read value; back-to-back issue
        run_cmd(WR_CMD, 5, "R9");
        rd_chk(2'd1, 32'h0000_8000, "R9");

        repeat (4) @(posedge clk);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule